// File: doc/BRIEF.md
# Output Mismatch Monitor for Fault Emulation

This block sits beside two copies of the same circuit: one with bit-flips injected into its registers and one left clean. Both copies receive the same stimulus every clock. The block compares their outputs bit by bit. For each output bit it counts how often the two copies differ during an observation window whose length is set in clock cycles.

At the end of the window, each output's count is checked against a tolerance. Control-type outputs, such as address lines, can be marked so that a single difference is a violation. A summary flag reports a violation on any of those marked outputs.

The same fault configuration is normally run several times. The block keeps, for each output, the sum of the counts and the sum of their squares over a series of runs. When the series ends it tests the spread of the counts against a threshold. The test uses integer arithmetic and needs no divider. A set bit marks a result that is not reproducible enough to trust.

Top module: `out_err_monitor`

## Requirements
- R1: A `start` pulse while `busy` is low clears every mismatch counter and opens a window of `windowLen` compare cycles; the first compare uses the inputs present at the clock edge after the one that sampled `start`; `start` while `busy` is high has no effect.
- R2: Output bit i of `errCount`, the slice `[i*CNT_W +: CNT_W]`, rises by one for every compare cycle in which `dutOut[i]` differs from `refOut[i]`; it stays unchanged outside the window.
- R3: Each mismatch counter saturates at 2^CNT_W-1 and never wraps.
- R4: `done` is high for exactly one cycle. It rises one clock after the last compare cycle, which is `windowLen`+1 edges after the edge that sampled `start`. With `windowLen` = 0 no compare takes place and `done` rises one edge after the start edge.
- R5: For an output whose `zeroTolMask` bit is 0, `rateViol[i]` is set when the final count is strictly greater than `maxCount[i*CNT_W +: CNT_W]`; a count equal to the limit passes. The flag is valid when `done` is high and holds until the next `done`.
- R6: For an output whose `zeroTolMask` bit is 1, `maxCount` is ignored and `rateViol[i]` is set for any nonzero count. `zeroTolHit` is the OR of `rateViol` over the marked outputs.
- R7: A series consists of N runs, where N is `numRuns` clamped to the range 1..MAX_RUNS (0 counts as 1). After the done of the N-th run, `varDone` pulses on the next cycle. At the same time `highVar[i]` is set exactly when N*S2 - S1*S1 > N*N*`varThresh`, where S1 and S2 are the sums of output i's counts and squared counts over the series. `highVar` holds until the next `varDone`.
- R8: The run that follows a `varDone` starts a new series; the sums from earlier runs do not carry into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Opens an observation window |
| windowLen | input | WIN_W | Compare cycles per window |
| numRuns | input | RUN_W | Runs per series, clamped to 1..MAX_RUNS |
| varThresh | input | THR_W | Spread threshold for the series test |
| maxCount | input | NUM_OUT*CNT_W | Per-output mismatch limit |
| zeroTolMask | input | NUM_OUT | Marks outputs that tolerate no mismatch |
| dutOut | input | NUM_OUT | Outputs of the fault-injected copy |
| refOut | input | NUM_OUT | Outputs of the clean copy |
| busy | output | 1 | Window or evaluation in progress |
| done | output | 1 | One-cycle pulse when window results are valid |
| varDone | output | 1 | One-cycle pulse when series results are valid |
| errCount | output | NUM_OUT*CNT_W | Per-output mismatch counts |
| rateViol | output | NUM_OUT | Per-output violation flags |
| zeroTolHit | output | 1 | A zero-tolerance output mismatched |
| highVar | output | NUM_OUT | Per-output high-spread flags |

## Verification
Each compare uses the inputs present at one clock edge inside the window. The counts are final after the last compare edge. `done`, `rateViol` and `zeroTolHit` are all due one edge later, and `varDone` and `highVar` one edge after that. The bench drives inputs on falling edges and samples at the falling edge that follows each of these register stages. In the cycle between the last compare and `done`, it forces mismatches on every bit to show that they are not counted. It checks `done` low one falling edge before its due cycle, high at its due cycle and low one cycle after. It checks `varDone` in its own due cycle, and checks it low in that cycle after runs that do not end a series.

// File: rtl/emon_pkg.sv
package emon_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_EVAL = 2'd2,
    ST_VCHK = 2'd3
  } ctrlStateT;

  typedef struct packed {
    logic clr;       // clear mismatch counters
    logic cmp;       // compare cycle inside the window
    logic eval;      // window closed: judge counts, accumulate
    logic firstRun;  // accumulation restarts the series sums
    logic varChk;    // series closed: spread test
  } strobeT;

endpackage

// File: rtl/emon_ctrl.sv
module emon_ctrl
  import emon_pkg::*;
#(
  parameter int WIN_W = 32,
  parameter int MAX_RUNS = 16,
  parameter int RUN_W = $clog2(MAX_RUNS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIN_W-1:0] windowLen,
  input  logic [RUN_W-1:0] numRuns,
  output strobeT           stb,
  output logic [RUN_W-1:0] runsEff,
  output logic             busy,
  output logic             done,
  output logic             varDone
);

  ctrlStateT        state;
  logic [WIN_W-1:0] remain;
  logic [RUN_W-1:0] runCnt;
  logic [RUN_W-1:0] runNext;

  always_comb begin
    if (numRuns == '0)                          runsEff = RUN_W'(1);
    else if (numRuns > RUN_W'(MAX_RUNS))        runsEff = RUN_W'(MAX_RUNS);
    else                                        runsEff = numRuns;
  end

  assign runNext = runCnt + RUN_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      remain  <= '0;
      runCnt  <= '0;
      done    <= 1'b0;
      varDone <= 1'b0;
    end else begin
      done    <= 1'b0;
      varDone <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          remain <= windowLen;
          state  <= (windowLen == '0) ? ST_EVAL : ST_RUN;
        end
        ST_RUN: begin
          remain <= remain - WIN_W'(1);
          if (remain == WIN_W'(1)) state <= ST_EVAL;
        end
        ST_EVAL: begin
          done   <= 1'b1;
          runCnt <= runNext;
          state  <= (runNext >= runsEff) ? ST_VCHK : ST_IDLE;
        end
        default: begin
          varDone <= 1'b1;
          runCnt  <= '0;
          state   <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    stb.clr      = (state == ST_IDLE) && start;
    stb.cmp      = (state == ST_RUN);
    stb.eval     = (state == ST_EVAL);
    stb.firstRun = (runCnt == '0);
    stb.varChk   = (state == ST_VCHK);
  end

  assign busy = (state != ST_IDLE);

  assert_start_opens_R1: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_series_after_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    varDone |-> $past(done));

endmodule

// File: rtl/emon_lane.sv
module emon_lane
  import emon_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int THR_W = 32,
  parameter int RUN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic             mismatch,
  input  logic [CNT_W-1:0] maxCnt,
  input  logic             zeroTol,
  input  logic [RUN_W-1:0] runsEff,
  input  logic [THR_W-1:0] thresh,
  output logic [CNT_W-1:0] cnt,
  output logic             viol,
  output logic             highVar
);

  localparam int S1_W   = CNT_W + RUN_W;
  localparam int S2_W   = 2 * CNT_W + RUN_W;
  localparam int PROD_W = 2 * S1_W + THR_W;

  logic [S1_W-1:0]   sum1;
  logic [S2_W-1:0]   sum2;
  logic [PROD_W-1:0] lhs;
  logic [PROD_W-1:0] rhs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.clr) begin
      cnt <= '0;
    end else if (stb.cmp && mismatch && (cnt != {CNT_W{1'b1}})) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      viol    <= 1'b0;
      sum1    <= '0;
      sum2    <= '0;
      highVar <= 1'b0;
    end else begin
      if (stb.eval) begin
        viol <= zeroTol ? (cnt != '0) : (cnt > maxCnt);
        sum1 <= (stb.firstRun ? '0 : sum1) + S1_W'(cnt);
        sum2 <= (stb.firstRun ? '0 : sum2) + (S2_W'(cnt) * S2_W'(cnt));
      end
      if (stb.varChk) highVar <= (lhs > rhs);
    end
  end

  always_comb begin
    lhs = (PROD_W'(runsEff) * PROD_W'(sum2)) - (PROD_W'(sum1) * PROD_W'(sum1));
    rhs = PROD_W'(runsEff) * PROD_W'(runsEff) * PROD_W'(thresh);
  end

  assert_no_wrap_R3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.clr |=> (cnt >= $past(cnt)));

  assert_hold_outside_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.cmp && !stb.clr) |=> $stable(cnt));

  assert_zero_tol_flag_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eval && zeroTol && (cnt != '0)) |=> viol);

endmodule

// File: rtl/emon_datapath.sv
module emon_datapath
  import emon_pkg::*;
#(
  parameter int NUM_OUT = 8,
  parameter int CNT_W = 32,
  parameter int THR_W = 32,
  parameter int RUN_W = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeT                   stb,
  input  logic [RUN_W-1:0]         runsEff,
  input  logic [THR_W-1:0]         varThresh,
  input  logic [NUM_OUT*CNT_W-1:0] maxCount,
  input  logic [NUM_OUT-1:0]       zeroTolMask,
  input  logic [NUM_OUT-1:0]       dutOut,
  input  logic [NUM_OUT-1:0]       refOut,
  output logic [NUM_OUT*CNT_W-1:0] errCount,
  output logic [NUM_OUT-1:0]       rateViol,
  output logic                     zeroTolHit,
  output logic [NUM_OUT-1:0]       highVar
);

  logic [NUM_OUT-1:0] diffBits;
  assign diffBits = dutOut ^ refOut;

  for (genvar i = 0; i < NUM_OUT; i++) begin : gLane
    emon_lane #(
      .CNT_W(CNT_W),
      .THR_W(THR_W),
      .RUN_W(RUN_W)
    ) uLane (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb),
      .mismatch(diffBits[i]),
      .maxCnt  (maxCount[i*CNT_W +: CNT_W]),
      .zeroTol (zeroTolMask[i]),
      .runsEff (runsEff),
      .thresh  (varThresh),
      .cnt     (errCount[i*CNT_W +: CNT_W]),
      .viol    (rateViol[i]),
      .highVar (highVar[i])
    );
  end

  assign zeroTolHit = |(rateViol & zeroTolMask);

endmodule

// File: rtl/out_err_monitor.sv
module out_err_monitor
  import emon_pkg::*;
#(
  parameter int NUM_OUT  = 8,
  parameter int CNT_W    = 32,
  parameter int WIN_W    = 32,
  parameter int THR_W    = 32,
  parameter int MAX_RUNS = 16,
  localparam int RUN_W   = $clog2(MAX_RUNS + 1)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [WIN_W-1:0]         windowLen,
  input  logic [RUN_W-1:0]         numRuns,
  input  logic [THR_W-1:0]         varThresh,
  input  logic [NUM_OUT*CNT_W-1:0] maxCount,
  input  logic [NUM_OUT-1:0]       zeroTolMask,
  input  logic [NUM_OUT-1:0]       dutOut,
  input  logic [NUM_OUT-1:0]       refOut,
  output logic                     busy,
  output logic                     done,
  output logic                     varDone,
  output logic [NUM_OUT*CNT_W-1:0] errCount,
  output logic [NUM_OUT-1:0]       rateViol,
  output logic                     zeroTolHit,
  output logic [NUM_OUT-1:0]       highVar
);

  strobeT           stb;
  logic [RUN_W-1:0] runsEff;

  emon_ctrl #(
    .WIN_W   (WIN_W),
    .MAX_RUNS(MAX_RUNS),
    .RUN_W   (RUN_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .windowLen(windowLen),
    .numRuns  (numRuns),
    .stb      (stb),
    .runsEff  (runsEff),
    .busy     (busy),
    .done     (done),
    .varDone  (varDone)
  );

  emon_datapath #(
    .NUM_OUT(NUM_OUT),
    .CNT_W  (CNT_W),
    .THR_W  (THR_W),
    .RUN_W  (RUN_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .runsEff    (runsEff),
    .varThresh  (varThresh),
    .maxCount   (maxCount),
    .zeroTolMask(zeroTolMask),
    .dutOut     (dutOut),
    .refOut     (refOut),
    .errCount   (errCount),
    .rateViol   (rateViol),
    .zeroTolHit (zeroTolHit),
    .highVar    (highVar)
  );

endmodule

// File: tb/tb_out_err_monitor.sv
`timescale 1ns/1ps
module tb_out_err_monitor;

  localparam int NO = 3;
  localparam int CW = 6;
  localparam int RW = 5;
  localparam longint SATV = 63;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [31:0] windowLen = '0;
  logic [RW-1:0] numRuns = '0;
  logic [31:0] varThresh = '0;
  logic [NO*CW-1:0] maxCount = '0;
  logic [NO-1:0] zeroTolMask = '0;
  logic [NO-1:0] dutOut = '0;
  logic [NO-1:0] refOut = '0;
  logic busy, done, varDone, zeroTolHit;
  logic [NO*CW-1:0] errCount;
  logic [NO-1:0] rateViol, highVar;

  out_err_monitor #(.NUM_OUT(NO), .CNT_W(CW), .WIN_W(32), .THR_W(32), .MAX_RUNS(16)) dut (
    .clk(clk), .rstN(rstN), .start(start), .windowLen(windowLen), .numRuns(numRuns),
    .varThresh(varThresh), .maxCount(maxCount), .zeroTolMask(zeroTolMask),
    .dutOut(dutOut), .refOut(refOut), .busy(busy), .done(done), .varDone(varDone),
    .errCount(errCount), .rateViol(rateViol), .zeroTolHit(zeroTolHit), .highVar(highVar));

  always #2 clk = ~clk;

  int nChk = 0;
  int nBad = 0;
  bit finished = 0;
  longint eCnt [NO];
  longint s1 [NO];
  longint s2 [NO];
  int runInSeries = 0;

  task automatic chk(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [NO-1:0] errPat(int k, int seed);
    logic [NO-1:0] p;
    for (int i = 0; i < NO; i++) p[i] = (((k * (i + 1) + seed) % (i + 2)) == 0);
    return p;
  endfunction

  function automatic longint effRuns();
    if (numRuns == 0) return 1;
    if (numRuns > 16) return 16;
    return longint'(numRuns);
  endfunction

  // one window; allPat forces mismatch on every bit; midStart pulses start inside the window
  task automatic runWin(int len, int seed, bit allPat, int midStart);
    longint n;
    @(negedge clk);
    start = 1'b1;
    dutOut = '1; refOut = '0;   // sampled on the start edge, must not count (R1)
    for (int i = 0; i < NO; i++) eCnt[i] = 0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < len; k++) begin
      logic [NO-1:0] p;
      p = allPat ? '1 : errPat(k, seed);
      refOut = NO'(k ^ seed);
      dutOut = refOut ^ p;
      start = (k == midStart);   // ignored while busy (R1)
      for (int i = 0; i < NO; i++) if (p[i] && eCnt[i] < SATV) eCnt[i]++;
      @(negedge clk);
    end
    start = 1'b0;
    chk("R4 done not early", longint'(done), 0);
    dutOut = '1; refOut = '0;    // outside window, not counted (R2)
    @(negedge clk);
    dutOut = '0;
    chk("R4 done due", longint'(done), 1);
    for (int i = 0; i < NO; i++) begin
      logic ev;
      chk("R2 R3 count", longint'(errCount[i*CW +: CW]), eCnt[i]);
      ev = zeroTolMask[i] ? (eCnt[i] != 0) : (eCnt[i] > longint'(maxCount[i*CW +: CW]));
      chk(zeroTolMask[i] ? "R6 zero-tol viol" : "R5 limit viol", longint'(rateViol[i]), longint'(ev));
    end
    begin
      logic zh = 1'b0;
      for (int i = 0; i < NO; i++) if (zeroTolMask[i] && eCnt[i] != 0) zh = 1'b1;
      chk("R6 zeroTolHit", longint'(zeroTolHit), longint'(zh));
    end
    if (runInSeries == 0) for (int i = 0; i < NO; i++) begin s1[i] = 0; s2[i] = 0; end
    for (int i = 0; i < NO; i++) begin s1[i] += eCnt[i]; s2[i] += eCnt[i] * eCnt[i]; end
    runInSeries++;
    @(negedge clk);
    chk("R4 done one cycle", longint'(done), 0);
    n = effRuns();
    if (runInSeries >= n) begin
      chk("R7 varDone", longint'(varDone), 1);
      for (int i = 0; i < NO; i++) begin
        longint l = n * s2[i] - s1[i] * s1[i];
        longint r = n * n * longint'(varThresh);
        chk("R7 R8 highVar", longint'(highVar[i]), longint'(l > r));
      end
      runInSeries = 0;
    end else begin
      chk("R7 no varDone mid-series", longint'(varDone), 0);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", longint'(busy), 0);
    chk("R4 reset done", longint'(done), 0);
    chk("R2 reset count", longint'(errCount), 0);
    chk("R7 reset highVar", longint'(highVar), 0);
    rstN = 1'b1;
    @(negedge clk);

    // mixed limits: out1 zero-tolerance, its limit ignored
    maxCount = {CW'(5), CW'(40), CW'(6)};
    zeroTolMask = 3'b010;
    numRuns = 3;
    varThresh = 2;
    windowLen = 20; runWin(20, 1, 0, 5);
    windowLen = 25; runWin(25, 4, 0, -1);
    windowLen = 9;  runWin(9, 7, 0, 3);

    // R8: new series, all runs equal -> zero spread
    varThresh = 0;
    for (int r = 0; r < 3; r++) begin windowLen = 12; runWin(12, 2, 0, -1); end

    // R4 zero-length window, numRuns 0 clamps to 1
    numRuns = 0; zeroTolMask = 3'b111;
    windowLen = 0; runWin(0, 0, 0, -1);
    windowLen = 1; runWin(1, 0, 1, -1);

    // R3 saturation, R5 equality passes
    numRuns = 1; zeroTolMask = 3'b000;
    maxCount = {CW'(62), CW'(63), CW'(0)};
    windowLen = 80; runWin(80, 0, 1, 40);

    // R7 clamp 20 -> 16 runs with varying counts
    numRuns = 20; varThresh = 1; zeroTolMask = 3'b100;
    maxCount = {CW'(0), CW'(2), CW'(1)};
    for (int r = 0; r < 16; r++) begin
      windowLen = 32'(3 + r % 5); runWin(3 + r % 5, r, 0, -1);
    end

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

endmodule